// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire host link that reads and writes a small register file inside a chip. The host holds a frame line low for the length of a transfer, toggles a serial clock, and moves bits over one data line. Each frame opens with a four-bit register address and a direction bit. Any data that follows is sized to the addressed register, from one bit up to 32.

On a write, incoming bits go into a holding register. The target register changes only when the frame line returns high. A short write replaces only the top bits of the register. A write that runs past the register width is applied at the first extra clock edge, and the bits after that are dropped. On a read, the block drives the register value out most significant bit first, starting right after the direction bit, and it stops driving once the frame closes.

One address acts as a soft-reset trigger. Writing it puts every register back to its default, which leaves the chip in power-down, and raises a one-cycle reset pulse for the rest of the chip. The bidirectional data line is split into a data input, a data output and an output enable, for a pad cell outside the block. The link inputs are taken to be synchronous to the system clock, and the block detects their edges against that clock.

Top module: `tw_regport`

## Requirements
- R1: After the reset input is released, every register holds its default value, the data output enable is low and the soft-reset pulse is low. The defaults are: frequency codes 0, control 0x00E0, slicer 0x200, wake control 0x0A5F00, wake rate 0x10400, wake address 0.
- R2: While the frame line is low, each rising serial-clock edge samples one data-input bit. The first four bits form the address, most significant bit first. The fifth bit selects the direction: 1 is a read and 0 is a write.
- R3: Register widths by address are: 0 to 3 are frequency codes of 32 bits, 4 is control (16), 5 is status (16), 6 is slicer (10), 7 is wake control (24), 8 is wake rate (18), 9 is wake address (16), and 15 is the reset trigger (1). A full-width write takes effect when the frame line rises.
- R4: A write of n bits, where n is below the register width, replaces the n most significant bits with the received bits and keeps the lower bits.
- R5: When a write clocks more bits than the register width, the register is updated at the first rising serial-clock edge beyond the width, with the frame still open. The bits after that edge and the later frame close change nothing.
- R6: In a read, the output enable rises after the direction-bit edge and stays high until the frame closes. The output shows the register's top bit first and moves to the next bit at each later rising edge. After the last bit it shows 0, and it is low whenever the enable is low.
- R7: Address 5 reads the status input as it stood at the direction-bit edge. Writes to address 5 are ignored.
- R8: Addresses 10 to 14 read as zero and ignore writes.
- R9: A write of at least one bit to address 15 returns every register to its default, which clears control bit 0 (power-down), and raises the soft-reset output for exactly one cycle.
- R10: A frame that closes before any data bit arrives, whether or not its header is complete, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Frame line, low during a transfer, rising edge closes it |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the pad |
| sdo_oe | output | 1 | Pad output enable for read data |
| status_in | input | STAT_W | Live status value for address 5 |
| soft_rst | output | 1 | One-cycle pulse after a reset-trigger write |
| freq0 | output | 32 | Frequency code register 0 |
| freq1 | output | 32 | Frequency code register 1 |
| freq2 | output | 32 | Frequency code register 2 |
| freq3 | output | 32 | Frequency code register 3 |
| ctrl | output | CTRL_W | Control register, bit 0 set means powered up |
| slicer | output | SLC_W | Slicer register |
| wk_ctrl | output | WKC_W | Wake control register |
| wk_rate | output | WKR_W | Wake rate register |
| wk_addr | output | WKA_W | Wake address register |

## Verification
Two update paths can reach a register: an over-long write applies itself on a clock edge while the frame is still open, and a normal write applies itself when the frame closes. If both fired, the register would be written twice. The bench writes 16 bits of one pattern to control, then clocks one extra edge and more bits of a different value. It checks control before the frame closes and again after the close, and expects the first pattern both times. A soft-reset write that lands on a trigger register of width one is also checked for a single reset pulse.

// File: rtl/tw_regport.sv
module tw_regport #(
  parameter int CTRL_W = 16,
  parameter int STAT_W = 16,
  parameter int SLC_W  = 10,
  parameter int WKC_W  = 24,
  parameter int WKR_W  = 18,
  parameter int WKA_W  = 16,
  parameter logic [31:0] CTRL_DEF = 32'h0000_00E0,
  parameter logic [31:0] SLC_DEF  = 32'h0000_0200,
  parameter logic [31:0] WKC_DEF  = 32'h000A_5F00,
  parameter logic [31:0] WKR_DEF  = 32'h0001_0400,
  parameter logic [31:0] WKA_DEF  = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [STAT_W-1:0] status_in,
  output logic              soft_rst,
  output logic [31:0]       freq0,
  output logic [31:0]       freq1,
  output logic [31:0]       freq2,
  output logic [31:0]       freq3,
  output logic [CTRL_W-1:0] ctrl,
  output logic [SLC_W-1:0]  slicer,
  output logic [WKC_W-1:0]  wk_ctrl,
  output logic [WKR_W-1:0]  wk_rate,
  output logic [WKA_W-1:0]  wk_addr
);
  localparam int         NREG      = 16;
  localparam logic [3:0] STAT_ADDR = 4'd5;
  localparam logic [3:0] RST_ADDR  = 4'd15;
  localparam logic [3:0] LAST_MAP  = 4'd9;
  localparam logic [2:0] HDR_BITS  = 3'd5;

  function automatic logic [5:0] wid(input logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd2, 4'd3: return 6'd32;
      4'd4:  return 6'(CTRL_W);
      4'd5:  return 6'(STAT_W);
      4'd6:  return 6'(SLC_W);
      4'd7:  return 6'(WKC_W);
      4'd8:  return 6'(WKR_W);
      4'd9:  return 6'(WKA_W);
      4'd15: return 6'd1;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [31:0] defv(input int i);
    case (i)
      4: return CTRL_DEF;
      6: return SLC_DEF;
      7: return WKC_DEF;
      8: return WKR_DEF;
      9: return WKA_DEF;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] lomask(input logic [5:0] n);
    return (n >= 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  logic [31:0] rf [NREG];
  logic        sclk_q, frame_q;
  logic [2:0]  hcnt;
  logic [3:0]  addr;
  logic        rw, done, oe;
  logic [5:0]  dcnt;
  logic [31:0] shreg, rdsh;

  wire sclk_rise  = sclk & ~sclk_q;
  wire frame_rise = frame_n & ~frame_q;
  wire [5:0] cur_w = wid(addr);
  wire in_write   = (hcnt == HDR_BITS) && !rw && !done;
  wire over       = sclk_rise && !frame_n && in_write && (dcnt == cur_w);
  wire close_wr   = frame_rise && in_write && (dcnt != 6'd0);
  wire commit     = over || close_wr;
  wire writable   = (addr <= LAST_MAP) && (addr != STAT_ADDR);

  wire [5:0]  keep_n = cur_w - dcnt;
  wire [31:0] wmask  = lomask(cur_w) & ~lomask(keep_n);
  wire [31:0] merged = (rf[addr] & ~wmask) | ((shreg << keep_n) & wmask);

  wire [31:0] rdval = (addr == STAT_ADDR) ? 32'(status_in) :
                      (addr <= LAST_MAP)  ? rf[addr] : 32'd0;
  wire [31:0] rd_al = (cur_w == 6'd0) ? 32'd0 : (rdval << (6'd32 - cur_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= defv(i);
      sclk_q   <= 1'b0;
      frame_q  <= 1'b1;
      hcnt     <= '0;
      addr     <= '0;
      rw       <= 1'b0;
      done     <= 1'b0;
      oe       <= 1'b0;
      dcnt     <= '0;
      shreg    <= '0;
      rdsh     <= '0;
      soft_rst <= 1'b0;
    end else begin
      sclk_q   <= sclk;
      frame_q  <= frame_n;
      soft_rst <= 1'b0;
      if (commit && addr == RST_ADDR) begin
        for (int i = 0; i < NREG; i++) rf[i] <= defv(i);
        soft_rst <= 1'b1;
      end else if (commit && writable) begin
        rf[addr] <= merged;
      end
      if (frame_n) begin
        hcnt <= '0;
        dcnt <= '0;
        done <= 1'b0;
        oe   <= 1'b0;
        rw   <= 1'b0;
      end else if (sclk_rise) begin
        if (hcnt < 3'd4) begin
          addr <= {addr[2:0], sdi};
          hcnt <= hcnt + 3'd1;
        end else if (hcnt == 3'd4) begin
          rw   <= sdi;
          hcnt <= HDR_BITS;
          if (sdi) begin
            rdsh <= rd_al;
            oe   <= 1'b1;
          end
        end else if (rw) begin
          rdsh <= rdsh << 1;
        end else if (!done) begin
          if (dcnt == cur_w) begin
            done <= 1'b1;
          end else begin
            shreg <= {shreg[30:0], sdi};
            dcnt  <= dcnt + 6'd1;
          end
        end
      end
    end
  end

  assign sdo_oe  = oe;
  assign sdo     = oe & rdsh[31];
  assign freq0   = rf[0];
  assign freq1   = rf[1];
  assign freq2   = rf[2];
  assign freq3   = rf[3];
  assign ctrl    = rf[4][CTRL_W-1:0];
  assign slicer  = rf[6][SLC_W-1:0];
  assign wk_ctrl = rf[7][WKC_W-1:0];
  assign wk_rate = rf[8][WKR_W-1:0];
  assign wk_addr = rf[9][WKA_W-1:0];
endmodule

// File: rtl/tw_regport_chk.sv
module tw_regport_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_n,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          soft_rst,
  input logic [31:0]   freq0,
  input logic [CW-1:0] ctrl
);
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && $past(frame_n)) |-> !sdo_oe); // R6

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo); // R6

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst); // R9

  AST_RST_PWRDN: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (ctrl[0] == 1'b0 && freq0 == 32'd0)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && $past(frame_n) && $past(frame_n, 2)) |-> ($stable(freq0) && $stable(ctrl))); // R3

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |=> ($stable(freq0) && $stable(ctrl))); // R2
endmodule

bind tw_regport tw_regport_chk #(.CW(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sdo(sdo), .sdo_oe(sdo_oe),
  .soft_rst(soft_rst), .freq0(freq0), .ctrl(ctrl)
);

// File: tb/tw_regport_tb.sv
`timescale 1ns/1ps
module tw_regport_tb;
  logic clk = 1'b0;
  logic rst_n, frame_n, sclk, sdi;
  logic sdo, sdo_oe, soft_rst;
  logic [15:0] status_in;
  logic [31:0] freq0, freq1, freq2, freq3;
  logic [15:0] ctrl;
  logic [9:0]  slicer;
  logic [23:0] wk_ctrl;
  logic [17:0] wk_rate;
  logic [15:0] wk_addr;

  always #2.5 clk = ~clk;

  tw_regport u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in), .soft_rst(soft_rst),
    .freq0(freq0), .freq1(freq1), .freq2(freq2), .freq3(freq3),
    .ctrl(ctrl), .slicer(slicer), .wk_ctrl(wk_ctrl), .wk_rate(wk_rate),
    .wk_addr(wk_addr)
  );

  // {addr, write bits, read bits, write data, expected read}
  localparam logic [79:0] VEC [12] = '{
    {4'd0,  6'd32, 6'd32, 32'hDEADBEEF, 32'hDEADBEEF}, // R3
    {4'd0,  6'd8,  6'd32, 32'h00000012, 32'h12ADBEEF}, // R4
    {4'd4,  6'd16, 6'd16, 32'h0000A5C3, 32'h0000A5C3}, // R3
    {4'd4,  6'd4,  6'd16, 32'h00000001, 32'h000015C3}, // R4
    {4'd6,  6'd10, 6'd10, 32'h000002AB, 32'h000002AB}, // R3
    {4'd6,  6'd3,  6'd10, 32'h00000002, 32'h0000012B}, // R4
    {4'd7,  6'd24, 6'd24, 32'h00123456, 32'h00123456}, // R3
    {4'd8,  6'd18, 6'd18, 32'h0003FFFF, 32'h0003FFFF}, // R3
    {4'd9,  6'd1,  6'd16, 32'h00000001, 32'h00008000}, // R4
    {4'd3,  6'd16, 6'd32, 32'h0000CAFE, 32'hCAFE0000}, // R4
    {4'd12, 6'd8,  6'd8,  32'h000000FF, 32'h00000000}, // R8
    {4'd5,  6'd16, 6'd16, 32'h00001234, 32'h0000BEEF}  // R7
  };

  int nchk = 0, nerr = 0, rstcnt = 0;
  bit finished = 0;

  always @(posedge clk) if (soft_rst) rstcnt++;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    sclk = 1'b0; sdi = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic fstart();
    frame_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic fend();
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    frame_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic hdr(input logic [3:0] a, input logic r);
    for (int i = 3; i >= 0; i--) sbit(a[i]);
    sbit(r);
  endtask

  task automatic wr(input logic [3:0] a, input int n, input logic [31:0] d);
    fstart(); hdr(a, 1'b0);
    for (int i = n - 1; i >= 0; i--) sbit(d[i]);
    fend();
  endtask

  task automatic rd_bits(input int n, output logic [31:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      v = {v[30:0], sdo};
      sbit(1'b0);
    end
  endtask

  task automatic rd(input logic [3:0] a, input int n, output logic [31:0] v);
    fstart(); hdr(a, 1'b1);
    rd_bits(n, v);
    fend();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [3:0]  a;
    logic [5:0]  wn, rn;
    logic [31:0] d, e, v;
    rst_n = 1'b0; frame_n = 1'b1; sclk = 1'b0; sdi = 1'b0; status_in = 16'hBEEF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(freq0, 32'h0, "R1 freq0");
    chk(32'(ctrl), 32'h00E0, "R1 ctrl");
    chk(32'(slicer), 32'h200, "R1 slicer");
    chk(32'(wk_ctrl), 32'h0A5F00, "R1 wk_ctrl");
    chk(32'(wk_rate), 32'h10400, "R1 wk_rate");
    chk(32'(sdo_oe), 32'h0, "R1 sdo_oe");
    chk(32'(soft_rst), 32'h0, "R1 soft_rst");

    // R2 R3 R4 R7 R8 table walk: write then read back
    for (int i = 0; i < 12; i++) begin
      {a, wn, rn, d, e} = VEC[i];
      wr(a, int'(wn), d);
      rd(a, int'(rn), v);
      chk(v, e, $sformatf("R2 vector %0d readback", i));
    end
    chk(32'(slicer), 32'h12B, "R4 slicer port");
    chk(freq3, 32'hCAFE0000, "R4 freq3 port");
    chk(32'(wk_addr), 32'h8000, "R4 wk_addr port");

    // R5 over-length write commits on first extra edge
    fstart(); hdr(4'd4, 1'b0);
    for (int i = 15; i >= 0; i--) sbit(i[0] ^ i[1] ? 1'b1 : 1'b0);
    sbit(1'b1);
    chk(32'(ctrl), 32'h6666, "R5 commit on extra edge");
    sbit(1'b0); sbit(1'b1); sbit(1'b1);
    fend();
    chk(32'(ctrl), 32'h6666, "R5 later bits ignored");

    // R6 read framing and trailing zeros
    fstart(); hdr(4'd4, 1'b1);
    chk(32'(sdo_oe), 32'h1, "R6 enable after direction bit");
    rd_bits(20, v);
    chk(v, 32'h66660, "R6 msb first then zeros");
    chk(32'(sdo_oe), 32'h1, "R6 enable held in frame");
    fend();
    chk(32'(sdo_oe), 32'h0, "R6 released after frame");
    chk(32'(sdo), 32'h0, "R6 quiet when released");

    // R10 header-only and short-header frames
    fstart(); hdr(4'd0, 1'b0); fend();
    chk(freq0, 32'h12ADBEEF, "R10 header only");
    fstart(); sbit(1'b0); sbit(1'b0); sbit(1'b0); fend();
    rd(4'd0, 32, v);
    chk(v, 32'h12ADBEEF, "R10 short header");

    // R9 soft reset
    rstcnt = 0;
    wr(4'd15, 1, 32'h1);
    chk(32'(rstcnt), 32'h1, "R9 single pulse");
    chk(freq0, 32'h0, "R9 freq0 default");
    chk(freq3, 32'h0, "R9 freq3 default");
    chk(32'(ctrl), 32'h00E0, "R9 ctrl default");
    chk(32'(ctrl[0]), 32'h0, "R9 power-down");
    chk(32'(slicer), 32'h200, "R9 slicer default");
    chk(32'(wk_ctrl), 32'h0A5F00, "R9 wk_ctrl default");
    chk(32'(wk_addr), 32'h0, "R9 wk_addr default");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule